// File: doc/BRIEF.md
# Edge Capture Event Counter

This block is one half of a general-purpose timer, fixed in input-capture operation. A capture pin is brought into the clock domain through a two-stage synchronizer. Edges are then picked out on the synchronized level according to a two-bit edge-select code. The 16-bit counter is extended by an 8-bit prescaler segment above it, which gives a 24-bit count. The match value is compared across all 24 bits.

Two modes are offered. In edge-count mode the counter moves by one on each qualifying edge, either upward from zero or downward from a load value. A match pulse fires when the new count equals the programmed match value. In edge-time mode the counter free-runs on every enabled cycle. A qualifying edge copies the running count into a capture register, and that register is what the block presents as its value. In both modes every qualifying edge produces a one-cycle event pulse. Dropping the enable parks the counter at its start value and silences all events.

Top module: `edge_capture_counter`

## Requirements
- R1: While rstN is low, value, capEvent and capMatch are all 0.
- R2: capIn passes two synchronizer flops before edge detection. A level change applied before rising edge k produces capEvent, and the matching counter or capture update, at rising edge k+2. A rising-only selection cannot qualify edges on two consecutive cycles.
- R3: edgeSel selects the qualifying edges: 2'b00 rising only, 2'b01 falling only, 2'b11 both, and 2'b10 none, so with 2'b10 nothing counts, nothing is captured and no event fires.
- R4: In edge-count mode (modeTime=0) with countUp=1, the counter is held at 0 while enable is low and adds 1 per qualifying edge, wrapping modulo 2^24. value shows the counter.
- R5: In edge-count mode with countUp=0, the counter is held at loadVal while enable is low and subtracts 1 per qualifying edge, wrapping from 0 to 24'hFFFFFF.
- R6: capEvent is a one-cycle pulse for each qualifying edge while enable is high, in either mode.
- R7: In edge-time mode (modeTime=1), the counter steps by one (up or down per countUp) on every enabled cycle. A qualifying edge copies the count held before that step into a capture register. value shows the capture register, which holds until the next qualifying edge and reads 0 while enable is low.
- R8: capMatch pulses together with capEvent only in edge-count mode, when the updated 24-bit count (bits 23:16 being the prescaler extension) equals matchVal. It never fires in edge-time mode.
- R9: While enable is low, no edge is qualified, capEvent and capMatch stay 0, and the counter sits at its start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; low holds the start value |
| modeTime | input | 1 | 0 edge-count mode, 1 edge-time mode |
| countUp | input | 1 | 1 counts upward, 0 downward |
| edgeSel | input | 2 | Qualifying edge code |
| loadVal | input | 24 | Start value for downward counting |
| matchVal | input | 24 | Event-count target for the match pulse |
| capIn | input | 1 | Asynchronous capture pin |
| value | output | 24 | Running count (edge-count) or captured count (edge-time) |
| capEvent | output | 1 | One-cycle pulse per qualifying edge |
| capMatch | output | 1 | One-cycle pulse when the count reaches matchVal |

## Verification
A level change on capIn becomes visible in capEvent, capMatch and the count or capture register at the third rising edge after it is applied. A change of enable or of the start value shows up at the next rising edge. The value output follows modeTime without any register in between. The bench drives every input at a falling edge and steps its own reference model once per rising edge. It compares all three outputs at the following falling edge, so the model carries the full synchronizer delay. Directed sequences also check the two-cycle-quiet, third-cycle-pulse latency explicitly, along with the downward wrap through zero.

// File: rtl/capt_pkg.sv
package capt_pkg;

  // Edge qualification codes; the encoding is part of the block's interface
  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_NONE = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  // Strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic holdStart;  // enable low: park counter at start, clear capture
    logic stepCnt;    // advance the counter by one
    logic latchNow;   // copy running count into capture register
    logic edgeHit;    // a qualifying edge was seen this cycle
  } captStrobe_t;

endpackage

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        modeTime,
  input  logic [1:0]  edgeSel,
  input  logic        capIn,
  output captStrobe_t strb
);

  // Synchronizer stages plus one extra flop holding the previous level
  logic [SYNC_STAGES:0] syncPipe;
  logic syncLvl, syncPrev, riseDet, fallDet, qualEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-1:0], capIn};
  end

  assign syncLvl  = syncPipe[SYNC_STAGES-1];
  assign syncPrev = syncPipe[SYNC_STAGES];
  assign riseDet  = syncLvl & ~syncPrev;
  assign fallDet  = ~syncLvl & syncPrev;

  always_comb begin
    unique case (edgeSel_e'(edgeSel))
      EDGE_RISE: qualEdge = riseDet;
      EDGE_FALL: qualEdge = fallDet;
      EDGE_BOTH: qualEdge = riseDet | fallDet;
      default:   qualEdge = 1'b0;
    endcase
  end

  always_comb begin
    strb.holdStart = ~enable;
    strb.edgeHit   = enable & qualEdge;
    strb.stepCnt   = enable & (modeTime | qualEdge);
    strb.latchNow  = enable & modeTime & qualEdge;
  end

  AST_RISE_SPACED: assert property (@(posedge clk) disable iff (!rstN)
    riseDet |=> !riseDet); // R2

endmodule

// File: rtl/capt_dpath.sv
module capt_dpath
  import capt_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int EXT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  captStrobe_t              strb,
  input  logic                     modeTime,
  input  logic                     countUp,
  input  logic [HALF_W+EXT_W-1:0]  loadVal,
  input  logic [HALF_W+EXT_W-1:0]  matchVal,
  output logic [HALF_W+EXT_W-1:0]  value,
  output logic                     capEvent,
  output logic                     capMatch
);

  localparam int TOT_W = HALF_W + EXT_W;

  // Counter kept as a half-width low part and a prescaler-extension high part
  logic [HALF_W-1:0] halfCnt, halfNext;
  logic [EXT_W-1:0]  extCnt, extNext;
  logic [TOT_W-1:0]  cnt, cntNext, startVal, capReg;
  logic              halfCarry;

  assign cnt      = {extCnt, halfCnt};
  assign startVal = countUp ? '0 : loadVal;

  always_comb begin
    if (countUp) begin
      halfNext  = halfCnt + 1'b1;
      halfCarry = &halfCnt;
      extNext   = extCnt + EXT_W'(halfCarry);
    end else begin
      halfNext  = halfCnt - 1'b1;
      halfCarry = ~|halfCnt;
      extNext   = extCnt - EXT_W'(halfCarry);
    end
    cntNext = {extNext, halfNext};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt  <= '0;
      extCnt   <= '0;
      capReg   <= '0;
      capEvent <= 1'b0;
      capMatch <= 1'b0;
    end else begin
      capEvent <= strb.edgeHit;
      capMatch <= strb.edgeHit & ~modeTime & (cntNext == matchVal);
      if (strb.holdStart)      {extCnt, halfCnt} <= startVal;
      else if (strb.stepCnt)   {extCnt, halfCnt} <= cntNext;
      if (strb.holdStart)      capReg <= '0;
      else if (strb.latchNow)  capReg <= cnt;
    end
  end

  assign value = modeTime ? capReg : cnt;

  AST_MATCH_WITH_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    capMatch |-> capEvent); // R8
  AST_NO_MATCH_IN_TIME: assert property (@(posedge clk) disable iff (!rstN)
    capMatch |-> !$past(modeTime)); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.holdStart) |-> (!capEvent && !capMatch)); // R9
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.latchNow) && !$past(strb.holdStart)) |-> $stable(capReg)); // R7

endmodule

// File: rtl/edge_capture_counter.sv
module edge_capture_counter
  import capt_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int EXT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic                    modeTime,
  input  logic                    countUp,
  input  logic [1:0]              edgeSel,
  input  logic [HALF_W+EXT_W-1:0] loadVal,
  input  logic [HALF_W+EXT_W-1:0] matchVal,
  input  logic                    capIn,
  output logic [HALF_W+EXT_W-1:0] value,
  output logic                    capEvent,
  output logic                    capMatch
);

  captStrobe_t strb;

  capt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .modeTime (modeTime),
    .edgeSel  (edgeSel),
    .capIn    (capIn),
    .strb     (strb)
  );

  capt_dpath #(.HALF_W(HALF_W), .EXT_W(EXT_W)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .modeTime (modeTime),
    .countUp  (countUp),
    .loadVal  (loadVal),
    .matchVal (matchVal),
    .value    (value),
    .capEvent (capEvent),
    .capMatch (capMatch)
  );

  AST_EVENT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    capEvent |-> $past(enable)); // R6

endmodule

// File: tb/edge_capture_counter_tb_top.sv
module edge_capture_counter_tb_top;

  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rstN;
  logic         enable, modeTime, countUp, capIn;
  logic [1:0]   edgeSel;
  logic [W-1:0] loadVal, matchVal, value;
  logic         capEvent, capMatch;

  always #4 clk = ~clk;

  edge_capture_counter dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .modeTime(modeTime),
    .countUp(countUp), .edgeSel(edgeSel), .loadVal(loadVal),
    .matchVal(matchVal), .capIn(capIn), .value(value),
    .capEvent(capEvent), .capMatch(capMatch)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state, stepped once per rising edge
  logic         mS1 = 0, mS2 = 0, mS3 = 0, mEv = 0, mMt = 0;
  logic [W-1:0] mCnt = '0, mLat = '0;

  function automatic logic selEdge(logic [1:0] sel, logic r, logic f);
    case (sel)
      2'b00:   return r;
      2'b01:   return f;
      2'b11:   return r | f;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic advance();
    logic qual;
    logic [W-1:0] nxt;
    qual = enable && selEdge(edgeSel, mS2 & ~mS3, ~mS2 & mS3);
    nxt  = countUp ? mCnt + 1'b1 : mCnt - 1'b1;
    mEv  = qual;
    mMt  = qual && !modeTime && (nxt == matchVal);
    if (!enable)                  mLat = '0;
    else if (modeTime && qual)    mLat = mCnt;
    if (!enable)                  mCnt = countUp ? '0 : loadVal;
    else if (modeTime || qual)    mCnt = nxt;
    mS3 = mS2; mS2 = mS1; mS1 = capIn;
  endtask

  task automatic cyc(string tag);
    advance();
    @(posedge clk);
    @(negedge clk);
    chk(tag, "value", value, modeTime ? mLat : mCnt);
    chk("R6", "capEvent", W'(capEvent), W'(mEv));
    chk("R8", "capMatch", W'(capMatch), W'(mMt));
  endtask

  task automatic runPhase(string tag, logic mt, logic up, logic [1:0] es,
                          logic [W-1:0] ld, logic [W-1:0] mv, int n, int prob);
    enable = 0; modeTime = mt; countUp = up; edgeSel = es;
    loadVal = ld; matchVal = mv;
    for (int i = 0; i < 4; i++) begin
      if ($urandom_range(99) < 30) capIn = ~capIn;
      cyc("R9");
    end
    enable = 1;
    for (int i = 0; i < n; i++) begin
      if ($urandom_range(99) < prob) capIn = ~capIn;
      cyc(tag);
    end
    enable = 0;
    cyc("R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit sawMatch;
    void'($urandom(32'd20240611));
    rstN = 0; enable = 0; modeTime = 0; countUp = 1; edgeSel = 2'b00;
    loadVal = '0; matchVal = '0; capIn = 0;
    repeat (3) @(negedge clk);
    capIn = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "value", value, '0);
    chk("R1", "capEvent", W'(capEvent), '0);
    chk("R1", "capMatch", W'(capMatch), '0);
    capIn = 0;
    @(negedge clk);
    rstN = 1;

    // R2: latency of a rising edge through the synchronizer
    matchVal = 24'd1;
    for (int i = 0; i < 4; i++) cyc("R9");
    enable = 1;
    for (int i = 0; i < 4; i++) cyc("R4");
    capIn = 1;
    cyc("R2"); chk("R2", "capEvent after 1 edge", W'(capEvent), '0);
    cyc("R2"); chk("R2", "capEvent after 2 edges", W'(capEvent), '0);
    cyc("R2"); chk("R2", "capEvent after 3 edges", W'(capEvent), W'(1'b1));
    chk("R4", "count after first edge", value, 24'd1);
    chk("R8", "match at count 1", W'(capMatch), W'(1'b1));
    enable = 0;
    cyc("R9");
    chk("R9", "parked at zero", value, '0);

    // R5: downward wrap through zero with both edges
    countUp = 0; loadVal = 24'd2; matchVal = 24'hFFFFFF; edgeSel = 2'b11;
    for (int i = 0; i < 3; i++) cyc("R9");
    chk("R5", "parked at load", value, 24'd2);
    enable = 1; sawMatch = 0;
    for (int e = 0; e < 3; e++) begin
      capIn = ~capIn;
      for (int i = 0; i < 4; i++) begin
        cyc("R5");
        if (capMatch) sawMatch = 1;
      end
    end
    chk("R5", "wrapped count", value, 24'hFFFFFF);
    chk("R8", "match at wrap", W'(sawMatch), W'(1'b1));
    enable = 0;
    cyc("R9");

    // R3: reserved code qualifies nothing
    runPhase("R3", 1'b0, 1'b1, 2'b10, '0, 24'd1, 60, 40);
    chk("R3", "no count with code 10", value, '0);
    // R3: falling-only and rising-only counting
    runPhase("R3", 1'b0, 1'b1, 2'b01, '0, 24'd5, 200, 20);
    runPhase("R3", 1'b0, 1'b0, 2'b00, 24'h010000, 24'h00FFFE, 200, 20);

    // R7: edge-time capture in both directions
    runPhase("R7", 1'b1, 1'b1, 2'b00, '0, '0, 300, 10);
    runPhase("R7", 1'b1, 1'b0, 2'b11, 24'h00FF00, '0, 300, 10);

    // Random phases
    for (int p = 0; p < 40; p++) begin
      logic mt, up;
      logic [1:0] es;
      logic [W-1:0] ld, mv;
      mt = 1'($urandom_range(1));
      up = 1'($urandom_range(1));
      case ($urandom_range(2))
        0: es = 2'b00;
        1: es = 2'b01;
        default: es = 2'b11;
      endcase
      ld = W'($urandom);
      mv = up ? W'($urandom_range(1, 30)) : ld - W'($urandom_range(1, 30));
      runPhase(mt ? "R7" : (up ? "R4" : "R5"), mt, up, es, ld, mv,
               $urandom_range(200, 400), $urandom_range(5, 40));
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule